// File: doc/BRIEF.md
# SAR Conversion Sequencer with Decision Timeout

This block is the synchronous digital controller for a 12-bit differential successive-approximation converter whose capacitor array is split into a thermometer-coded fine segment and a redundant coarse segment. A sample strobe starts a conversion of fourteen decision cycles. Three fine cycles drive seven equal-weight elements through a binary search on the thermometer level. Eleven coarse cycles then each commit one upper/lower switch pair. Because the coarse segment has two more cycles than a plain binary search, a late correction can still recover an early wrong decision.

Each decision cycle has two halves. In the regenerate half the comparator is armed and the block waits for its ready flag. In the one-clock reset half the comparator is re-armed. If the comparator has not resolved before a programmable number of clocks, a watchdog forces the decision, records a default bit and sets a flag that stays high for the rest of that conversion. The conversion then carries on, so it never stalls. All raw decision bits are kept for a later error-correction stage. The analog comparator and the capacitors are outside the block and appear only as pins.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset the outputs are as follows. busy, cmp_arm, done, meta, fine_on are 0. fine_sw, crs_up, crs_dn and dec_bits are all zero. All switches are then at the midpoint.
- R2: In idle, a high start at a clock edge begins a conversion. From the next cycle busy and cmp_arm are 1. fine_on is still 0 and all switch controls are 0, so the first comparison is made before any capacitor moves.
- R3: A conversion has 14 decision cycles. In the regenerate half (cmp_arm=1), a high cmp_rdy at a clock edge takes cmp_dec as the decision. The following cycle is a single reset half with cmp_arm=0. The next regenerate half comes after that, unless the decision was the last one.
- R4: Fine array: fine_sw bit i high means element i is at the high level. After decision 0, fine_on=1 and the level is 4 (fine_sw=0001111). Decision 1 moves the level by +2 (decision 1) or -2 (decision 0). Decision 2 then moves it by +1 or -1. fine_sw is always the thermometer code of the level.
- R5: Coarse decision k (k=0..10, overall decision 3+k) sets pair 10-k to crs_up=decision and crs_dn=inverse. A pair has crs_up=crs_dn=0 (midpoint) until its own decision, and it keeps its value until the conversion ends.
- R6: Overall decision i (i=0..13) is stored in dec_bits[13-i]. dec_bits clears when a conversion starts.
- R7: If cmp_rdy stays low for TIMEOUT (default 16) clocks of a regenerate half, the decision is forced to 0. meta is set, the reset half follows, and the remaining cycles still run. meta stays set until the next conversion starts.
- R8: On the clock after the reset half of the last decision, done is 1 for exactly one cycle. On that same clock busy falls, all switches return to midpoint (fine_on=0, fine_sw, crs_up, crs_dn zero), and dec_bits and meta are held.
- R9: A start while busy is ignored. The running conversion keeps its timing, its decisions and its meta flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample strobe, starts a conversion when idle |
| cmp_dec | input | 1 | Comparator result, 1 = upper node higher |
| cmp_rdy | input | 1 | Comparator has resolved |
| cmp_arm | output | 1 | 1 = regenerate half, 0 = comparator reset |
| busy | output | 1 | Conversion in progress |
| fine_on | output | 1 | Fine array has left the midpoint |
| fine_sw | output | 7 | Fine thermometer switch controls |
| crs_up | output | 11 | Coarse upper-side controls |
| crs_dn | output | 11 | Coarse lower-side controls |
| dec_bits | output | 14 | Raw decisions, first decision in bit 13 |
| meta | output | 1 | A decision in this conversion was forced by timeout |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong cycle index or a lost phase shows in the next reset half. The fine level or a coarse pair then differs from the pattern the decisions so far imply, so the bench compares every switch output after each decision. A watchdog counting error shows as a regenerate half that is not exactly TIMEOUT clocks long. A broken sticky flag or stored bit shows at the done pulse, where the scoreboard compares dec_bits and meta with the values predicted for that conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int FINE_BITS  = 3;
    localparam int CRS_CYC    = 11;
    localparam int FINE_ELEMS = (1 << FINE_BITS) - 1;
    localparam int N_CYC      = FINE_BITS + CRS_CYC;
    localparam int CYC_W      = $clog2(N_CYC);
    localparam int LVL_W      = FINE_BITS + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REGEN,
        ST_RESET
    } seq_state_e;

    // One accepted comparator decision, broadcast to the switch arrays
    typedef struct packed {
        logic             commit;
        logic             val;
        logic [CYC_W-1:0] idx;
    } sar_dec_t;

    // Thermometer code of a level: elements below the level are high
    function automatic logic [FINE_ELEMS-1:0] therm(input logic [LVL_W-1:0] lvl);
        logic [FINE_ELEMS-1:0] t;
        for (int i = 0; i < FINE_ELEMS; i++) begin
            t[i] = (LVL_W'(i) < lvl);
        end
        return t;
    endfunction

    // Search step for fine decision idx: the start level for idx 0, then halves
    function automatic logic [LVL_W-1:0] fine_step(input int idx);
        return LVL_W'(1) << (FINE_BITS - 1 - idx);
    endfunction

endpackage

// File: rtl/sar_dec_watchdog.sv
module sar_dec_watchdog
    import sar_seq_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rdy,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    assign expire = run && !rdy && (cnt == CW'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || rdy || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_wd_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TIMEOUT - 1));

    p_wd_leave_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> !run);

endmodule

// File: rtl/sar_fine_array.sv
module sar_fine_array
    import sar_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  sar_dec_t              dec,
    output logic                  fine_on,
    output logic [FINE_ELEMS-1:0] fine_sw
);
    logic [LVL_W-1:0] lvl;
    logic             fine_hit;

    assign fine_hit = dec.commit && (dec.idx < CYC_W'(FINE_BITS));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl     <= '0;
            fine_on <= 1'b0;
        end else if (fine_hit) begin
            if (dec.idx == '0) begin
                lvl     <= fine_step(0);
                fine_on <= 1'b1;
            end else if (dec.val) begin
                lvl <= lvl + fine_step(int'(dec.idx));
            end else begin
                lvl <= lvl - fine_step(int'(dec.idx));
            end
        end
    end

    assign fine_sw = therm(lvl);

    p_fine_therm_r4: assert property (@(posedge clk) disable iff (rst)
        (fine_sw & (fine_sw + 1'b1)) == '0);

    p_fine_second_r4: assert property (@(posedge clk) disable iff (rst)
        (fine_hit && dec.idx == CYC_W'(1) && !clr) |=>
            ($countones(fine_sw) == 2 || $countones(fine_sw) == 6));

    p_fine_mid_r2: assert property (@(posedge clk) disable iff (rst)
        !fine_on |-> fine_sw == '0);

endmodule

// File: rtl/sar_coarse_array.sv
module sar_coarse_array
    import sar_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  sar_dec_t           dec,
    output logic [CRS_CYC-1:0] crs_up,
    output logic [CRS_CYC-1:0] crs_dn
);
    // Pair j is owned by overall decision FINE_BITS + CRS_CYC - 1 - j
    for (genvar j = 0; j < CRS_CYC; j++) begin : g_pair
        localparam int OWN_IDX = FINE_BITS + CRS_CYC - 1 - j;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                crs_up[j] <= 1'b0;
                crs_dn[j] <= 1'b0;
            end else if (dec.commit && dec.idx == CYC_W'(OWN_IDX)) begin
                crs_up[j] <= dec.val;
                crs_dn[j] <= !dec.val;
            end
        end
    end

    p_pair_excl_r5: assert property (@(posedge clk) disable iff (rst)
        (crs_up & crs_dn) == '0);

    p_pair_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (($past(crs_up | crs_dn) & ~(crs_up | crs_dn)) == '0));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  cmp_dec,
    input  logic                  cmp_rdy,
    output logic                  cmp_arm,
    output logic                  busy,
    output logic                  fine_on,
    output logic [FINE_ELEMS-1:0] fine_sw,
    output logic [CRS_CYC-1:0]    crs_up,
    output logic [CRS_CYC-1:0]    crs_dn,
    output logic [N_CYC-1:0]      dec_bits,
    output logic                  meta,
    output logic                  done
);
    seq_state_e       state;
    logic [CYC_W-1:0] cyc;
    logic             run;
    logic             expire;
    logic             last;
    logic             accept;
    logic             finish;
    logic             clr;
    sar_dec_t         dec;

    assign run     = (state == ST_REGEN);
    assign last    = (cyc == CYC_W'(N_CYC - 1));
    assign accept  = (state == ST_IDLE) && start;
    assign finish  = (state == ST_RESET) && last;
    assign clr     = accept || finish;
    assign cmp_arm = run;
    assign busy    = (state != ST_IDLE);

    assign dec.commit = run && (cmp_rdy || expire);
    assign dec.val    = cmp_rdy ? cmp_dec : 1'b0;
    assign dec.idx    = cyc;

    sar_dec_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .rdy    (cmp_rdy),
        .expire (expire)
    );

    sar_fine_array u_fine (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .dec     (dec),
        .fine_on (fine_on),
        .fine_sw (fine_sw)
    );

    sar_coarse_array u_crs (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .dec    (dec),
        .crs_up (crs_up),
        .crs_dn (crs_dn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cyc   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_REGEN;
                        cyc   <= '0;
                    end
                end
                ST_REGEN: begin
                    if (dec.commit) state <= ST_RESET;
                end
                ST_RESET: begin
                    if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cyc   <= cyc + 1'b1;
                        state <= ST_REGEN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            dec_bits <= '0;
            meta     <= 1'b0;
        end else if (dec.commit) begin
            dec_bits[CYC_W'(N_CYC - 1) - cyc] <= dec.val;
            if (!cmp_rdy) meta <= 1'b1;
        end
    end

    p_arm_drop_r3: assert property (@(posedge clk) disable iff (rst)
        dec.commit |=> !cmp_arm);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && fine_sw == '0 && crs_up == '0 && crs_dn == '0));

    p_meta_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && meta) |=> meta);

    p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !finish) |=> busy);

endmodule

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmp_dec = 1'b0;
    logic        cmp_rdy = 1'b0;
    logic        cmp_arm, busy, fine_on, meta, done;
    logic [6:0]  fine_sw;
    logic [10:0] crs_up, crs_dn;
    logic [13:0] dec_bits;

    int nchk = 0;
    int nerr = 0;
    logic [14:0] exp_q[$];

    always #2.5 clk = ~clk;

    sar_seq_ctrl #(.TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cmp_dec(cmp_dec), .cmp_rdy(cmp_rdy),
        .cmp_arm(cmp_arm), .busy(busy), .fine_on(fine_on), .fine_sw(fine_sw),
        .crs_up(crs_up), .crs_dn(crs_dn), .dec_bits(dec_bits), .meta(meta), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops the predicted result at every done pulse (R6, R7, R9)
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", 32'(done), 32'(0));
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk(dec_bits == e[13:0], "R6 dec_bits", 32'(dec_bits), 32'(e[13:0]));
                chk(meta == e[14], "R7 meta", 32'(meta), 32'(e[14]));
            end
        end
    end

    // Driver: d gives the comparator answers, tmo marks decisions left to time out
    task automatic run_conv(input logic [13:0] d, input logic [13:0] tmo, input bit poke);
        int lvl;
        logic [10:0] eu, ed;
        exp_q.push_back({|tmo, d & ~tmo});
        lvl = 0; eu = '0; ed = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && cmp_arm, "R2 busy/arm after start", 32'({busy, cmp_arm}), 32'(3));
        chk(!fine_on && fine_sw == 0 && crs_up == 0 && crs_dn == 0, "R2 midpoint at first compare",
            32'({fine_on, fine_sw}), 32'(0));
        for (int i = 0; i < 14; i++) begin
            logic b;
            b = tmo[13-i] ? 1'b0 : d[13-i];
            if (tmo[13-i]) begin
                int cnt;
                cnt = 0;
                while (cmp_arm && cnt < 100) begin
                    cnt++;
                    @(negedge clk);
                end
                chk(cnt == TMO, "R7 regenerate length before forced decision", 32'(cnt), 32'(TMO));
            end else begin
                cmp_dec = d[13-i];
                cmp_rdy = 1'b1;
                @(negedge clk);
                cmp_rdy = 1'b0;
            end
            chk(!cmp_arm && busy, "R3 reset half after decision", 32'({cmp_arm, busy}), 32'(1));
            if (i == 0) lvl = 4;
            else if (i == 1) lvl = b ? lvl + 2 : lvl - 2;
            else if (i == 2) lvl = b ? lvl + 1 : lvl - 1;
            else begin
                eu[13-i] = b;
                ed[13-i] = !b;
            end
            chk(fine_on && fine_sw == 7'((1 << lvl) - 1), "R4 fine thermometer",
                32'(fine_sw), 32'((1 << lvl) - 1));
            chk(crs_up == eu && crs_dn == ed, "R5 coarse pairs", 32'({crs_up, crs_dn}), 32'({eu, ed}));
            if (poke && (i == 5 || i == 9)) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (i < 13) chk(cmp_arm, "R3 next regenerate half", 32'(cmp_arm), 32'(1));
        end
        chk(done && !busy, "R8 done with busy low", 32'({done, busy}), 32'(2));
        chk(!fine_on && fine_sw == 0 && crs_up == 0 && crs_dn == 0, "R8 switches back to midpoint",
            32'({fine_on, fine_sw, crs_up}), 32'(0));
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", 32'(done), 32'(0));
        chk(dec_bits == (d & ~tmo), "R8 dec_bits held after done", 32'(dec_bits), 32'(d & ~tmo));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cmp_arm && !done && !meta && !fine_on, "R1 reset flags",
            32'({busy, cmp_arm, done, meta, fine_on}), 32'(0));
        chk(fine_sw == 0 && crs_up == 0 && crs_dn == 0 && dec_bits == 0, "R1 reset switches",
            32'({fine_sw, crs_up}), 32'(0));
        run_conv(14'h3FFF, 14'h0000, 1'b0);
        run_conv(14'h0000, 14'h0000, 1'b0);
        run_conv(14'h2AAA, 14'h0000, 1'b1);   // R9 start while busy
        run_conv(14'h1555, 14'h1010, 1'b0);   // R7 timeouts in fine and coarse
        run_conv(14'h2C3A, 14'h0000, 1'b0);   // R7 meta clears on next start
        run_conv(14'h3FFF, 14'h2001, 1'b1);   // R7 first and last timed out, R9
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all conversions completed", 32'(exp_q.size()), 32'(0));
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule